// File: doc/BRIEF.md
# Early Receive Threshold Interrupt Logic

This block follows the frame that the receive MAC is delivering and counts its bytes. When the count goes past a threshold the host has programmed, the block raises an early-receive flag. The host can then start work on the frame before it has fully arrived. The flag is raised at most once per frame, and only while the frame sits at the head of the receive queue, where the host can move it during reception. A threshold written below the minimum byte count needed for destination address filtering is raised to that minimum.

When the frame ends, the block raises a receive-complete flag. Receive-complete overrides early-receive: it clears any pending early flag in the same cycle, so the two flags are never set together. The early flag is cleared by the host through a write-one-to-clear acknowledge. A new set in the same cycle as an acknowledge wins.

The block also tells the receive DMA engine when it may begin on the current frame. With early start enabled, DMA may begin once the threshold number of bytes has arrived. With early start disabled, DMA may begin only at frame end.

Top module: `rx_early_thresh`

## Requirements
- R1: With the top flag high, the early flag goes high in the cycle after the clock edge at which the frame's byte count becomes strictly greater than the effective threshold. It then stays high until it is cleared.
- R2: The early flag is raised at most once per frame. After it has been acknowledged, further bytes of the same frame do not raise it again.
- R3: The early flag is never raised while the top flag is low. If the top flag rises after the count has already passed the threshold, the flag is raised one cycle later.
- R4: A threshold write with a value below MIN_THR (default 8) stores MIN_THR. Any other value is stored unchanged. After reset the stored threshold is THR_RESET.
- R5: If a frame ends before its count passes the threshold, only the complete flag is raised and the early flag stays low for that frame.
- R6: The complete flag goes high in the cycle after a frame-end strobe inside a frame. In that same cycle the early flag is low, and the two flags are never high together.
- R7: With early start enabled, the DMA-eligible flag goes high in the cycle after the edge at which the count reaches the threshold (count greater than or equal to the threshold).
- R8: With early start disabled, the DMA-eligible flag goes high only together with the complete flag, at frame end.
- R9: A frame-start strobe clears the complete flag, the DMA-eligible flag, the byte count and the record of an early event for the frame. Byte strobes are counted only inside a frame.
- R10: A one on the acknowledge input clears the early flag on the next edge. If a set condition occurs at the same edge, the flag is set instead.
- R11: After reset the early, complete and DMA-eligible flags are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | Strobe marking the start of a received frame |
| byte_valid_i | input | 1 | One received frame byte this cycle |
| frame_end_i | input | 1 | Strobe marking the end of the frame |
| top_frame_i | input | 1 | Current frame is at the head of the receive queue |
| thr_wr_i | input | 1 | Threshold register write strobe |
| thr_wdata_i | input | CNT_W | Threshold write value |
| early_en_i | input | 1 | Allow DMA to start at the threshold instead of at frame end |
| early_ack_i | input | 1 | Write-one-to-clear acknowledge for the early flag |
| early_ind_o | output | 1 | Early-receive indication |
| complete_ind_o | output | 1 | Receive-complete indication |
| dma_ok_o | output | 1 | Current frame is eligible for receive DMA |

## Verification
The assertions check on every cycle that the early and complete flags are never high together. They also check that a rising early flag followed a high top flag, that the flag has not already fired in the current frame, and that the stored threshold never falls below the minimum. They further check that a frame start clears the complete flag, and that without early start the DMA flag only rises together with completion. The exact cycle at which the flags rise for each threshold and frame length, and the clamping of small threshold writes, can only be seen in the bench's sweep over thresholds, lengths, top states and enable settings. The same holds for the acknowledge behaviour, including an acknowledge that collides with a set.

// File: rtl/rx_early_pkg.sv
package rx_early_pkg;
   typedef enum logic {
      CNT_WRAP = 1'b0,
      CNT_SAT  = 1'b1
   } cnt_mode_e;
endpackage

// File: rtl/rx_thr_reg.sv
module rx_thr_reg #(
   parameter int CNT_W     = 8,
   parameter int MIN_THR   = 8,
   parameter int THR_RESET = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wdata_i,
   output logic [CNT_W-1:0] thr_o
);
   localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_THR);
   localparam logic [CNT_W-1:0] RST_V = CNT_W'(THR_RESET);

   logic [CNT_W-1:0] thr_q;

   // small writes are raised to the filtering minimum
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         thr_q <= RST_V;
      else if (wr_i)
         thr_q <= (wdata_i < MIN_V) ? MIN_V : wdata_i;
   end

   assign thr_o = thr_q;
endmodule

// File: rtl/rx_byte_cnt.sv
module rx_byte_cnt
   import rx_early_pkg::*;
#(
   parameter int        CNT_W = 8,
   parameter cnt_mode_e MODE  = CNT_SAT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_nx_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] base;

   assign base = clr_i ? '0 : cnt_q;

   generate
      if (MODE == CNT_SAT) begin : g_sat
         always_comb begin
            if (inc_i && (base != CNT_MAX))
               cnt_nx_o = base + 1'b1;
            else
               cnt_nx_o = base;
         end
      end else begin : g_wrap
         always_comb cnt_nx_o = base + CNT_W'(inc_i);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else
         cnt_q <= cnt_nx_o;
   end
endmodule

// File: rtl/rx_early_evt.sv
module rx_early_evt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start_i,
   input  logic             frame_end_i,
   input  logic             top_frame_i,
   input  logic             early_en_i,
   input  logic             early_ack_i,
   input  logic [CNT_W-1:0] cnt_nx_i,
   input  logic [CNT_W-1:0] thr_i,
   output logic             active_eff_o,
   output logic             fired_o,
   output logic             early_o,
   output logic             complete_o,
   output logic             dma_ok_o
);
   logic active_q, fired_q, early_q, complete_q, dma_q;
   logic fired_eff, set_early, set_cmp, dma_hit;

   assign active_eff_o = frame_start_i | active_q;
   assign fired_eff    = fired_q & ~frame_start_i;
   assign set_cmp      = active_eff_o & frame_end_i;
   // completion in the same cycle suppresses an early event
   assign set_early    = active_eff_o & ~fired_eff & top_frame_i &
                         (cnt_nx_i > thr_i) & ~set_cmp;
   assign dma_hit      = active_eff_o & early_en_i & (cnt_nx_i >= thr_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q   <= 1'b0;
         fired_q    <= 1'b0;
         early_q    <= 1'b0;
         complete_q <= 1'b0;
         dma_q      <= 1'b0;
      end else begin
         active_q <= active_eff_o & ~set_cmp;
         fired_q  <= fired_eff | set_early;
         if (set_cmp)
            early_q <= 1'b0;
         else if (set_early)
            early_q <= 1'b1;
         else if (early_ack_i)
            early_q <= 1'b0;
         if (set_cmp)
            complete_q <= 1'b1;
         else if (frame_start_i)
            complete_q <= 1'b0;
         dma_q <= dma_hit | set_cmp | (dma_q & ~frame_start_i);
      end
   end

   assign fired_o    = fired_q;
   assign early_o    = early_q;
   assign complete_o = complete_q;
   assign dma_ok_o   = dma_q;
endmodule

// File: rtl/rx_early_thresh.sv
module rx_early_thresh
   import rx_early_pkg::*;
#(
   parameter int        CNT_W     = 8,
   parameter int        MIN_THR   = 8,
   parameter int        THR_RESET = 8,
   parameter cnt_mode_e CNT_MODE  = CNT_SAT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start_i,
   input  logic             byte_valid_i,
   input  logic             frame_end_i,
   input  logic             top_frame_i,
   input  logic             thr_wr_i,
   input  logic [CNT_W-1:0] thr_wdata_i,
   input  logic             early_en_i,
   input  logic             early_ack_i,
   output logic             early_ind_o,
   output logic             complete_ind_o,
   output logic             dma_ok_o
);
   localparam int CNT_LIMIT = (1 << CNT_W) - 1;

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_w
         $error("rx_early_thresh: CNT_W out of range");
      end
      if (MIN_THR < 1 || MIN_THR >= CNT_LIMIT) begin : g_bad_min
         $error("rx_early_thresh: MIN_THR does not fit the counter");
      end
      if (THR_RESET < MIN_THR || THR_RESET > CNT_LIMIT) begin : g_bad_rst
         $error("rx_early_thresh: THR_RESET out of range");
      end
   endgenerate

   logic [CNT_W-1:0] thr_q;
   logic [CNT_W-1:0] cnt_nx;
   logic             active_eff;
   logic             fired_q;

   rx_thr_reg #(
      .CNT_W(CNT_W), .MIN_THR(MIN_THR), .THR_RESET(THR_RESET)
   ) u_thr (
      .clk(clk), .rst_n(rst_n), .wr_i(thr_wr_i),
      .wdata_i(thr_wdata_i), .thr_o(thr_q)
   );

   rx_byte_cnt #(
      .CNT_W(CNT_W), .MODE(CNT_MODE)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(frame_start_i),
      .inc_i(byte_valid_i & active_eff), .cnt_nx_o(cnt_nx)
   );

   rx_early_evt #(
      .CNT_W(CNT_W)
   ) u_evt (
      .clk(clk), .rst_n(rst_n),
      .frame_start_i(frame_start_i), .frame_end_i(frame_end_i),
      .top_frame_i(top_frame_i), .early_en_i(early_en_i),
      .early_ack_i(early_ack_i), .cnt_nx_i(cnt_nx), .thr_i(thr_q),
      .active_eff_o(active_eff), .fired_o(fired_q),
      .early_o(early_ind_o), .complete_o(complete_ind_o),
      .dma_ok_o(dma_ok_o)
   );
endmodule

// File: rtl/rx_early_thresh_chk.sv
module rx_early_thresh_chk #(
   parameter int CNT_W   = 8,
   parameter int MIN_THR = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_start_i,
   input logic             frame_end_i,
   input logic             top_frame_i,
   input logic             early_en_i,
   input logic             early_ind_o,
   input logic             complete_ind_o,
   input logic             dma_ok_o,
   input logic [CNT_W-1:0] thr_q,
   input logic             fired_q
);
   // R6
   excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(early_ind_o && complete_ind_o));

   // R6
   cmp_clears_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(complete_ind_o) |-> !early_ind_o);

   // R3
   early_needs_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(early_ind_o) |-> $past(top_frame_i));

   // R2
   once_per_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(early_ind_o) |-> (!$past(fired_q) || $past(frame_start_i)));

   // R4
   thr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      thr_q >= CNT_W'(MIN_THR));

   // R8
   dma_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dma_ok_o) && !$past(early_en_i)) |-> complete_ind_o);

   // R9
   start_clears_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(frame_start_i) && !$past(frame_end_i)) |-> !complete_ind_o);
endmodule

bind rx_early_thresh rx_early_thresh_chk #(
   .CNT_W(CNT_W), .MIN_THR(MIN_THR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i),
   .frame_end_i(frame_end_i), .top_frame_i(top_frame_i),
   .early_en_i(early_en_i), .early_ind_o(early_ind_o),
   .complete_ind_o(complete_ind_o), .dma_ok_o(dma_ok_o),
   .thr_q(thr_q), .fired_q(fired_q)
);

// File: tb/rx_early_thresh_tb.sv
`timescale 1ns/1ps
module rx_early_thresh_tb;
   localparam int CNT_W   = 8;
   localparam int MIN_THR = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_start_i = 0, byte_valid_i = 0, frame_end_i = 0, top_frame_i = 0;
   logic thr_wr_i = 0, early_en_i = 0, early_ack_i = 0;
   logic [CNT_W-1:0] thr_wdata_i = '0;
   logic early_ind_o, complete_ind_o, dma_ok_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   rx_early_thresh #(.CNT_W(CNT_W), .MIN_THR(MIN_THR), .THR_RESET(MIN_THR)) u_dut (
      .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i),
      .byte_valid_i(byte_valid_i), .frame_end_i(frame_end_i),
      .top_frame_i(top_frame_i), .thr_wr_i(thr_wr_i), .thr_wdata_i(thr_wdata_i),
      .early_en_i(early_en_i), .early_ack_i(early_ack_i),
      .early_ind_o(early_ind_o), .complete_ind_o(complete_ind_o),
      .dma_ok_o(dma_ok_o)
   );

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic write_thr(input int w);
      thr_wr_i = 1'b1; thr_wdata_i = CNT_W'(w);
      tick();
      thr_wr_i = 1'b0;
   endtask

   task automatic start_frame();
      frame_start_i = 1'b1;
      tick();
      frame_start_i = 1'b0;
   endtask

   task automatic end_frame();
      frame_end_i = 1'b1;
      tick();
      frame_end_i = 1'b0;
   endtask

   task automatic bytes(input int n);
      for (int i = 0; i < n; i++) begin
         byte_valid_i = 1'b1;
         tick();
      end
      byte_valid_i = 1'b0;
   endtask

   // one frame of len bytes with written threshold w; outputs checked after every edge
   task automatic sweep_frame(input int w, input int len, input bit top, input bit en);
      int eff;
      eff = (w < MIN_THR) ? MIN_THR : w;
      write_thr(w);
      early_en_i = en; top_frame_i = top;
      start_frame();
      chk("R9", "complete after start", complete_ind_o, 1'b0);
      chk("R9", "dma after start", dma_ok_o, 1'b0);
      chk("R1", "early after start", early_ind_o, 1'b0);
      for (int k = 1; k <= len; k++) begin
         byte_valid_i = 1'b1;
         tick();
         chk(top ? ((eff == w) ? "R1" : "R4") : "R3", "early mid frame",
             early_ind_o, top && (k > eff));
         chk(en ? "R7" : "R8", "dma mid frame", dma_ok_o, en && (k >= eff));
         chk("R6", "complete mid frame", complete_ind_o, 1'b0);
      end
      byte_valid_i = 1'b0;
      end_frame();
      chk("R6", "complete at end", complete_ind_o, 1'b1);
      chk((len > eff) ? "R6" : "R5", "early at end", early_ind_o, 1'b0);
      chk("R8", "dma at end", dma_ok_o, 1'b1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk("R11", "early in reset", early_ind_o, 1'b0);
      chk("R11", "complete in reset", complete_ind_o, 1'b0);
      chk("R11", "dma in reset", dma_ok_o, 1'b0);
      rst_n = 1'b1;
      tick();
      chk("R11", "early after reset", early_ind_o, 1'b0);
      chk("R11", "dma after reset", dma_ok_o, 1'b0);

      // bytes outside a frame are not counted (R9)
      top_frame_i = 1'b1; early_en_i = 1'b0;
      bytes(20);
      start_frame();
      bytes(8);
      chk("R9", "stray bytes not counted", early_ind_o, 1'b0);
      bytes(1);
      chk("R1", "early at byte 9", early_ind_o, 1'b1);
      end_frame();

      // sweep threshold, length, top and enable
      foreach (int_thr_list[t]) begin end
      for (int wi = 0; wi < 7; wi++) begin
         int w;
         case (wi)
            0: w = 0; 1: w = 3; 2: w = 7; 3: w = 8;
            4: w = 9; 5: w = 12; default: w = 20;
         endcase
         for (int len = 0; len <= 25; len++)
            for (int m = 0; m < 4; m++)
               sweep_frame(w, len, m[0], m[1]);
      end

      // acknowledge clears, and no second event in the frame
      write_thr(8); top_frame_i = 1'b1; early_en_i = 1'b1;
      start_frame();
      bytes(9);
      chk("R1", "early set before ack", early_ind_o, 1'b1);
      early_ack_i = 1'b1;
      tick();
      early_ack_i = 1'b0;
      chk("R10", "ack clears early", early_ind_o, 1'b0);
      bytes(10);
      chk("R2", "no second early", early_ind_o, 1'b0);
      end_frame();

      // acknowledge collides with set
      start_frame();
      bytes(8);
      early_ack_i = 1'b1; byte_valid_i = 1'b1;
      tick();
      early_ack_i = 1'b0; byte_valid_i = 1'b0;
      chk("R10", "set wins over ack", early_ind_o, 1'b1);
      end_frame();
      chk("R6", "complete clears early", early_ind_o, 1'b0);

      // top rises late
      top_frame_i = 1'b0;
      start_frame();
      bytes(12);
      chk("R3", "no early while not top", early_ind_o, 1'b0);
      top_frame_i = 1'b1;
      tick();
      chk("R3", "early after late top", early_ind_o, 1'b1);
      end_frame();

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   int int_thr_list[1];

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule